// File: doc/BRIEF.md
# Reset Source Controller with Flags

The controller merges three reset requests into one stretched system reset and leaves a sticky record of which request caused the most recent reset. The requests are an active-low external reset pin, a supply comparator output that reads high while the supply sits above its threshold, and a single-cycle timeout pulse from a missing-clock detector. The comparator, the pin pull-up and the clock detector live outside the block and arrive here as digital inputs. The pin and the comparator pass through synchronizers. The timeout pulse is taken as already synchronous to `clk_i`.

Software sees two byte-wide registers on a simple bus with an address, a write strobe, write data and combinational read data. Address 0 is the supply-monitor control register. Address 1 is the reset-source register. A supply dip causes a reset only when the monitor is enabled in the control register and also selected as a reset source in the reset-source register. Both of these settings survive every reset except the power-on input `rst_ni`, which clears all state.

Top module: `rst_src_ctrl`

## Requirements
- R1: In the control register (address 0), bit 7 is a read/write monitor enable and bit 6 is a read-only live supply status: 1 when `sup_ok_i` is high (supply above threshold), 0 otherwise, seen two clock edges after the input changes.
- R2: Bits 5:0 of the control register always read 0, and writes to them have no effect.
- R3: A low `sup_ok_i` requests a reset only while the enable (address 0 bit 7) and the source select (address 1 bit 1) are both 1. With either one at 0, the supply state never asserts `sys_rst_o`.
- R4: A low `ext_rst_ni` asserts `sys_rst_o`. When that reset ends, bit 0 of the reset-source register reads 1.
- R5: A pulse on `clk_miss_i` asserts `sys_rst_o`. Bit 2 of the reset-source register reads 1 after a reset caused by it, and reads 0 after a reset with any other cause.
- R6: When a reset caused by the supply monitor ends, bit 3 of the reset-source register reads 1.
- R7: When a reset ends, only the flag of its cause is set and the other two flags (bits 0, 2, 3) are cleared. The cause is the source of the last request sampled before the release. If several sources are sampled at that same edge, the pin wins over the supply, and the supply wins over the missing clock.
- R8: `sys_rst_o` falls exactly STRETCH clock edges after the last edge that sampled a request. A one-cycle `clk_miss_i` pulse therefore gives STRETCH cycles of reset. A released pin or a recovered supply gives STRETCH+1 cycles, counted from the first edge after the input change, because of the two-stage synchronizer.
- R9: `rst_ni` low clears both registers and holds `sys_rst_o` high. `sys_rst_o` falls on the STRETCH-th edge after `rst_ni` rises, and all flags then read 0. A reset from any other source leaves the enable and source-select bits unchanged.
- R10: Flag bits 0, 2 and 3 ignore writes and change only at the edge where `sys_rst_o` falls. Reset-source bits 7:4 read 0, and addresses 2 and 3 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous to clk_i |
| sup_ok_i | input | 1 | Supply comparator, 1 = above threshold |
| clk_miss_i | input | 1 | Missing-clock timeout pulse, synchronous |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the addressed register |
| sys_rst_o | output | 1 | Stretched system reset, active high |

## Verification
Cause capture and request arbitration can coincide when two sources are sampled at the same final clock edge before release. The bench provokes this by timing a missing-clock pulse onto the same edge where the synchronized pin request is seen for the last time. It then judges the recorded flag, which must be the pin's bit 0 alone. In the reverse ordering the pulse lands after the pin request has stopped, so the most recent cause must win and bit 2 must read alone.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PIN  = 2'd1,
    CAUSE_SUP  = 2'd2,
    CAUSE_MCLK = 2'd3
  } cause_e;

  localparam int unsigned REQ_PIN  = 0;
  localparam int unsigned REQ_SUP  = 1;
  localparam int unsigned REQ_MCLK = 2;
  localparam int unsigned NUM_REQ  = 3;

  localparam int unsigned ADDR_MON = 0;
  localparam int unsigned ADDR_SRC = 1;

  localparam int unsigned MON_EN_BIT   = 7;
  localparam int unsigned MON_STAT_BIT = 6;
  localparam int unsigned SRC_PIN_BIT  = 0;
  localparam int unsigned SRC_SEL_BIT  = 1;
  localparam int unsigned SRC_MCLK_BIT = 2;
  localparam int unsigned SRC_SUP_BIT  = 3;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= RST_VAL[g];
        else         sh_q <= d_i[g];
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= {STAGES{RST_VAL[g]}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i[g]};
      end
    end
    assign q_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/rsc_stretch.sv
module rsc_stretch
  import rsc_pkg::*;
#(
  parameter int unsigned STRETCH = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_REQ-1:0] req_i,
  output logic               sys_rst_o,
  output logic               release_o,
  output cause_e             cause_o
);
  localparam int unsigned CNT_W = $clog2(STRETCH + 1);

  logic [CNT_W-1:0] cnt_q;
  cause_e           cause_q;
  cause_e           pick;
  logic             any_req;

  assign any_req = |req_i;

  // fixed priority on a tie: pin, then supply, then missing clock
  always_comb begin
    if (req_i[REQ_PIN])      pick = CAUSE_PIN;
    else if (req_i[REQ_SUP]) pick = CAUSE_SUP;
    else if (req_i[REQ_MCLK]) pick = CAUSE_MCLK;
    else                     pick = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CNT_W'(STRETCH);
      cause_q <= CAUSE_NONE;
    end else if (any_req) begin
      cnt_q   <= CNT_W'(STRETCH);
      cause_q <= pick;
    end else if (cnt_q != '0) begin
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign sys_rst_o = (cnt_q != '0);
  assign release_o = !any_req && (cnt_q == CNT_W'(1));
  assign cause_o   = cause_q;
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic              sup_stat_i,
  input  logic              release_i,
  input  cause_e            cause_i,
  output logic              mon_en_o,
  output logic              src_sel_o,
  output logic [7:0]        rdata_o
);
  logic en_q, sel_q;
  logic flag_pin_q, flag_sup_q, flag_mclk_q;
  logic sel_mon, sel_src;
  logic unused_wdata;

  assign sel_mon = (addr_i == ADDR_W'(ADDR_MON));
  assign sel_src = (addr_i == ADDR_W'(ADDR_SRC));
  assign unused_wdata = ^{wdata_i[6:2], wdata_i[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (we_i) begin
      if (sel_mon) en_q  <= wdata_i[MON_EN_BIT];
      if (sel_src) sel_q <= wdata_i[SRC_SEL_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_pin_q  <= 1'b0;
      flag_sup_q  <= 1'b0;
      flag_mclk_q <= 1'b0;
    end else if (release_i) begin
      flag_pin_q  <= (cause_i == CAUSE_PIN);
      flag_sup_q  <= (cause_i == CAUSE_SUP);
      flag_mclk_q <= (cause_i == CAUSE_MCLK);
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (sel_mon) begin
      rdata_o[MON_EN_BIT]   = en_q;
      rdata_o[MON_STAT_BIT] = sup_stat_i;
    end else if (sel_src) begin
      rdata_o[SRC_PIN_BIT]  = flag_pin_q;
      rdata_o[SRC_SEL_BIT]  = sel_q;
      rdata_o[SRC_MCLK_BIT] = flag_mclk_q;
      rdata_o[SRC_SUP_BIT]  = flag_sup_q;
    end
  end

  assign mon_en_o  = en_q;
  assign src_sel_o = sel_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rsc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned STRETCH     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_rst_ni,
  input  logic              sup_ok_i,
  input  logic              clk_miss_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              sys_rst_o
);
  logic [1:0]         sync_q;
  logic               pin_n_s, sup_ok_s;
  logic               mon_en, src_sel;
  logic               rel;
  cause_e             cause;
  logic [NUM_REQ-1:0] req;

  rsc_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sup_ok_i, ext_rst_ni}),
    .q_o   (sync_q)
  );

  assign pin_n_s  = sync_q[0];
  assign sup_ok_s = sync_q[1];

  assign req[REQ_PIN]  = !pin_n_s;
  assign req[REQ_SUP]  = mon_en && src_sel && !sup_ok_s;
  assign req[REQ_MCLK] = clk_miss_i;

  rsc_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .sys_rst_o(sys_rst_o),
    .release_o(rel),
    .cause_o  (cause)
  );

  rsc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (reg_addr_i),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .sup_stat_i(sup_ok_s),
    .release_i (rel),
    .cause_i   (cause),
    .mon_en_o  (mon_en),
    .src_sel_o (src_sel),
    .rdata_o   (reg_rdata_o)
  );
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk #(
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_rdata_o,
  input logic              sys_rst_o,
  input logic [2:0]        req_i
);
  // R2
  p_low_bits_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(0)) |-> (reg_rdata_o[5:0] == 6'd0));

  // R8
  p_req_forces_rst_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> sys_rst_o);

  // R8
  p_release_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_o) |-> $past(req_i == 3'b000));

  // R7
  p_flags_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_W'(1)) |->
      $onehot0({reg_rdata_o[3], reg_rdata_o[2], reg_rdata_o[0]}));

  // R10
  p_flags_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_addr_i == ADDR_W'(1)) && ($past(reg_addr_i) == ADDR_W'(1)) && !$fell(sys_rst_o))
      |-> $stable({reg_rdata_o[3], reg_rdata_o[2], reg_rdata_o[0]}));

  // R10
  p_unused_addr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i > ADDR_W'(1)) |-> (reg_rdata_o == 8'h00));
endmodule

bind rst_src_ctrl rst_src_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_rdata_o(reg_rdata_o),
  .sys_rst_o  (sys_rst_o),
  .req_i      (req)
);

// File: tb/rst_src_ctrl_test.sv
`timescale 1ns/1ps
module rst_src_ctrl_test;
  localparam int unsigned STRETCH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_n = 1'b1;
  logic       sup_ok = 1'b1;
  logic       miss = 1'b0;
  logic [1:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sys_rst;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rst_src_ctrl #(.ADDR_W(2), .STRETCH(STRETCH), .SYNC_STAGES(2)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .ext_rst_ni (ext_n),
    .sup_ok_i   (sup_ok),
    .clk_miss_i (miss),
    .reg_addr_i (addr),
    .reg_we_i   (we),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .sys_rst_o  (sys_rst)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic count_high(output int n);
    n = 0;
    while (sys_rst && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_por();
    logic [7:0] d;
    int n;
    rst_n = 1'b0;
    idle(3);
    chk("R9", "rst out during power-on", int'(sys_rst), 1);
    rst_n = 1'b1;
    @(negedge clk);
    count_high(n);
    chk("R9", "power-on stretch samples", n, STRETCH - 1);
    rd(2'd0, d); chk("R9", "control after power-on", d, 8'h40);
    rd(2'd1, d); chk("R9", "source after power-on", d, 8'h00);
  endtask

  task automatic t_ctrl_reg();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d); chk("R2", "control after 0xFF write", d, 8'hC0);
    wr(2'd0, 8'h3F);
    rd(2'd0, d); chk("R1", "enable cleared, low bits ignored", d, 8'h40);
    sup_ok = 1'b0;
    idle(3);
    rd(2'd0, d); chk("R1", "status low", d, 8'h00);
    chk("R3", "no reset with monitor off", int'(sys_rst), 0);
    sup_ok = 1'b1;
    idle(3);
    rd(2'd0, d); chk("R1", "status high", d, 8'h40);
  endtask

  task automatic t_sup_gating();
    logic [7:0] d;
    int n;
    sup_ok = 1'b0;
    wr(2'd0, 8'h80);
    idle(5);
    chk("R3", "enable without select", int'(sys_rst), 0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    idle(5);
    chk("R3", "select without enable", int'(sys_rst), 0);
    wr(2'd0, 8'h80);
    idle(2);
    chk("R3", "enable and select", int'(sys_rst), 1);
    idle(4);
    sup_ok = 1'b1;
    @(negedge clk);
    count_high(n);
    chk("R8", "supply recovery stretch", n, STRETCH + 1);
    rd(2'd1, d); chk("R6", "supply flag with select kept", d, 8'h0A);
    rd(2'd0, d); chk("R9", "enable kept over supply reset", d, 8'hC0);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'hFD);
    rd(2'd1, d); chk("R10", "flags ignore writes", d, 8'h08);
  endtask

  task automatic t_pin();
    logic [7:0] d;
    int n;
    ext_n = 1'b0;
    idle(10);
    chk("R4", "pin forces reset", int'(sys_rst), 1);
    ext_n = 1'b1;
    @(negedge clk);
    count_high(n);
    chk("R8", "pin release stretch", n, STRETCH + 1);
    rd(2'd1, d); chk("R7", "pin flag alone", d, 8'h01);
  endtask

  task automatic t_mclk();
    logic [7:0] d;
    int n;
    @(negedge clk);
    miss = 1'b1;
    @(negedge clk);
    miss = 1'b0;
    count_high(n);
    chk("R8", "missing clock stretch", n, STRETCH);
    rd(2'd1, d); chk("R5", "missing clock flag", d, 8'h04);
    ext_n = 1'b0;
    idle(4);
    ext_n = 1'b1;
    idle(1);
    count_high(n);
    rd(2'd1, d); chk("R5", "mclk flag cleared by pin reset", d, 8'h01);
  endtask

  task automatic t_overlap();
    logic [7:0] d;
    int n;
    ext_n = 1'b0;
    idle(5);
    ext_n = 1'b1;        // before edge r
    @(negedge clk);      // edge r passed, pin request still seen at r+1
    miss = 1'b1;
    @(negedge clk);
    miss = 1'b0;
    count_high(n);
    chk("R8", "tie stretch", n, STRETCH);
    rd(2'd1, d); chk("R7", "tie resolved to pin", d, 8'h01);
    ext_n = 1'b0;
    idle(5);
    ext_n = 1'b1;
    idle(4);
    miss = 1'b1;
    @(negedge clk);
    miss = 1'b0;
    count_high(n);
    rd(2'd1, d); chk("R7", "latest cause wins", d, 8'h04);
  endtask

  task automatic t_por_clears();
    logic [7:0] d;
    int n;
    wr(2'd0, 8'h80);
    wr(2'd1, 8'h02);
    rd(2'd2, d); chk("R10", "address 2 reads zero", d, 8'h00);
    rd(2'd3, d); chk("R10", "address 3 reads zero", d, 8'h00);
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
    count_high(n);
    rd(2'd0, d); chk("R9", "power-on clears enable", d, 8'h40);
    rd(2'd1, d); chk("R9", "power-on clears select and flags", d, 8'h00);
  endtask

  initial begin
    t_por();
    t_ctrl_reg();
    t_sup_gating();
    t_pin();
    t_mclk();
    t_overlap();
    t_por_clears();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule